// File: doc/BRIEF.md
# Acknowledgement-pending tracker for one edge-triggered interrupt line

This block sits beside an interrupt controller and follows a single edge-triggered line that software wants acknowledged by every destination before the line fires again. When a delivery on the line is attempted, the controller reports which destinations took the interrupt and which vector was used. The block marks each accepting destination as owing an end-of-interrupt (EOI) and stores that destination's vector. It also loads a count of acknowledgements still owed.

While that count is non-zero the block raises a registered coalesced flag. The controller uses the flag to refuse further assertions of the line, and the block itself ignores any delivery reported while the flag is high. EOI events name one destination and one vector. Only an EOI that matches a pending destination and its stored vector retires that destination.

The count and the pending bitmap can disagree, for example after a failed delivery that marked destinations but loaded a zero count. If a matching EOI arrives while the count is already zero, the block rebuilds itself from a per-destination snapshot of current pending status supplied by the controller. Reset is applied asynchronously and released through a two-stage synchronizer.

Top module: `eoi_pend_tracker`

## Requirements
- R1: `coalesced` is a register that is high exactly when `pend_count` is non-zero; both change on the clock edge that samples the causing event.
- R2: A delivery presented while `coalesced` is high is ignored: the count is unchanged and no pending bit or stored vector is touched, so a later EOI carrying the refused vector from a destination outside the earlier mask has no effect.
- R3: A delivery presented while `coalesced` is low is taken. The count is loaded with the number of set bits in `dlv_mask`, saturated at 2^CNT_W-1, when `dlv_ok` is 1, and with 0 when `dlv_ok` is 0.
- R4: A taken delivery sets the pending bit of every destination whose `dlv_mask` bit is 1 (bit i is destination i), and stores `dlv_vector` as that destination's vector. This applies whether `dlv_ok` is 1 or 0.
- R5: An EOI from destination `eoi_dest` clears its pending bit and decrements the count by one, but only when that bit is set and `eoi_vector` equals the stored vector. Any other EOI leaves count and bitmap unchanged.
- R6: A matching EOI that arrives while the count is 0 rebuilds the block. Each bitmap bit becomes the matching `cur_pending` bit, each destination with `cur_pending` set stores `cur_vector`, and the count becomes the number of set bits in `cur_pending`, saturated.
- R7: When a delivery and an EOI arrive in the same cycle, the delivery is applied first. The EOI is then judged against the bitmap, vectors and count as left by that delivery.
- R8: Reset clears the count, the coalesced flag and the whole bitmap. After reset, an EOI with `cur_pending` all ones has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dlv_valid | input | 1 | A delivery on the tracked line is reported this cycle |
| dlv_ok | input | 1 | The reported delivery succeeded |
| dlv_mask | input | NUM_DEST | Destinations that accepted the delivery, bit i = destination i |
| dlv_vector | input | VEC_W | Vector used by the delivery |
| eoi_valid | input | 1 | An EOI event is present this cycle |
| eoi_dest | input | $clog2(NUM_DEST) | Destination issuing the EOI |
| eoi_vector | input | VEC_W | Vector named by the EOI |
| cur_pending | input | NUM_DEST | Current per-destination pending status, used only on rebuild |
| cur_vector | input | VEC_W | Vector currently programmed for the line, used only on rebuild |
| coalesced | output | 1 | Acknowledgements still owed; new assertions must be refused |
| pend_count | output | CNT_W | Number of acknowledgements still owed |

## Verification
Every one of the 256 accept masks is delivered. Each destination then sends a wrong-vector EOI and a right-vector EOI, which separates vector comparison from bit tracking and shows each mask bit landing on its own destination. Between the two, a delivery is offered while coalesced with the complementary mask and a new vector, and EOIs for that vector are sent. These tell a truly ignored delivery apart from one that silently sets bits.

All 256 rebuild snapshots are driven after a failed delivery, then drained, to show the rebuilt count and the rebuilt vectors. A same-cycle delivery-plus-EOI pair and a reset during pending activity, followed by an EOI with all destinations reported pending, separate delivery-first ordering and a true bitmap clear from their wrong counterparts.

// File: rtl/eoi_trk_pkg.sv
package eoi_trk_pkg;

  // Clamp a population count to what the counter register can hold.
  function automatic int unsigned sat_cnt(input int unsigned n, input int unsigned lim);
    return (n > lim) ? lim : n;
  endfunction

endpackage

// File: rtl/eoi_dest_slot.sv
module eoi_dest_slot #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dlv_take,
  input  logic             dlv_sel,
  input  logic [VEC_W-1:0] dlv_vector,
  input  logic             eoi_valid,
  input  logic             eoi_sel,
  input  logic [VEC_W-1:0] eoi_vector,
  input  logic             rebuild,
  input  logic             cur_pend,
  input  logic [VEC_W-1:0] cur_vector,
  output logic             hit
);

  logic             pend_q, pend_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             set_now, bit_mid, slot_en;
  logic [VEC_W-1:0] vec_mid;

  // Delivery is folded in first, then the EOI is judged against the result.
  always_comb begin
    set_now = dlv_take & dlv_sel;
    bit_mid = pend_q | set_now;
    vec_mid = set_now ? dlv_vector : vec_q;
    hit     = eoi_valid & eoi_sel & bit_mid & (vec_mid == eoi_vector);
  end

  always_comb begin
    slot_en = set_now | hit | rebuild;
    if (rebuild) begin
      pend_d = cur_pend;
      vec_d  = cur_pend ? cur_vector : vec_mid;
    end else begin
      pend_d = bit_mid & ~hit;
      vec_d  = vec_mid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else if (slot_en) begin
      pend_q <= pend_d;
      vec_q  <= vec_d;
    end
  end

  // R4: an accepting destination becomes pending with the delivered vector
  p_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_now && !hit && !rebuild |=> pend_q && (vec_q == $past(dlv_vector)));

  // R5: a matching EOI retires the destination
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !rebuild |=> !pend_q);

  // R7: a same-cycle delivery and matching EOI leave the destination retired
  p_dlv_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_take && dlv_sel && eoi_valid && eoi_sel && (dlv_vector == eoi_vector) && !rebuild
    |=> !pend_q);

endmodule

// File: rtl/eoi_pend_counter.sv
module eoi_pend_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dlv_take,
  input  logic             dlv_ok,
  input  logic [CNT_W-1:0] dlv_load,
  input  logic             eoi_hit,
  input  logic [CNT_W-1:0] rebuild_load,
  output logic             rebuild,
  output logic [CNT_W-1:0] count,
  output logic             coalesced
);

  logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_d;
  logic             coal_q, coal_d, cnt_en;

  always_comb begin
    cnt_mid = dlv_take ? (dlv_ok ? dlv_load : '0) : cnt_q;
    rebuild = eoi_hit & (cnt_mid == '0);
    if (rebuild)      cnt_d = rebuild_load;
    else if (eoi_hit) cnt_d = cnt_mid - 1'b1;
    else              cnt_d = cnt_mid;
    coal_d = (cnt_d != '0);
    cnt_en = dlv_take | eoi_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      coal_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      coal_q <= coal_d;
    end
  end

  assign count     = cnt_q;
  assign coalesced = coal_q;

  // R1: flag and count agree at every edge
  p_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    coalesced == (count != '0));

  // R5: a retiring EOI without delivery or rebuild removes exactly one
  p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_hit && !dlv_take && !rebuild |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/eoi_pend_tracker.sv
module eoi_pend_tracker #(
  parameter int NUM_DEST = 8,
  parameter int VEC_W    = 8,
  parameter int CNT_W    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        dlv_valid,
  input  logic                        dlv_ok,
  input  logic [NUM_DEST-1:0]         dlv_mask,
  input  logic [VEC_W-1:0]            dlv_vector,
  input  logic                        eoi_valid,
  input  logic [$clog2(NUM_DEST)-1:0] eoi_dest,
  input  logic [VEC_W-1:0]            eoi_vector,
  input  logic [NUM_DEST-1:0]         cur_pending,
  input  logic [VEC_W-1:0]            cur_vector,
  output logic                        coalesced,
  output logic [CNT_W-1:0]            pend_count
);
  import eoi_trk_pkg::*;

  localparam int DEST_W  = $clog2(NUM_DEST);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic                rst_meta, rst_sync_n;
  logic                dlv_take, eoi_hit, rebuild;
  logic [NUM_DEST-1:0] eoi_sel, hit_vec;
  logic [CNT_W-1:0]    dlv_load, rebuild_load;

  // Assert at once, release two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    dlv_take     = dlv_valid & ~coalesced;
    eoi_sel      = '0;
    eoi_sel[eoi_dest] = 1'b1;
    eoi_hit      = |hit_vec;
    dlv_load     = CNT_W'(sat_cnt($countones(dlv_mask), CNT_MAX));
    rebuild_load = CNT_W'(sat_cnt($countones(cur_pending), CNT_MAX));
  end

  for (genvar i = 0; i < NUM_DEST; i++) begin : g_slot
    eoi_dest_slot #(.VEC_W(VEC_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .dlv_take   (dlv_take),
      .dlv_sel    (dlv_mask[i]),
      .dlv_vector (dlv_vector),
      .eoi_valid  (eoi_valid),
      .eoi_sel    (eoi_sel[i]),
      .eoi_vector (eoi_vector),
      .rebuild    (rebuild),
      .cur_pend   (cur_pending[i]),
      .cur_vector (cur_vector),
      .hit        (hit_vec[i])
    );
  end

  eoi_pend_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .dlv_take     (dlv_take),
    .dlv_ok       (dlv_ok),
    .dlv_load     (dlv_load),
    .eoi_hit      (eoi_hit),
    .rebuild_load (rebuild_load),
    .rebuild      (rebuild),
    .count        (pend_count),
    .coalesced    (coalesced)
  );

  // R2: a refused delivery leaves the count alone
  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dlv_valid && coalesced && !eoi_valid |=> pend_count == $past(pend_count));

  // R3: a taken delivery loads the saturated accept count, or zero on failure
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dlv_valid && !coalesced && !eoi_valid |=>
      pend_count == ($past(dlv_ok) ?
        CNT_W'(sat_cnt($countones($past(dlv_mask)), CNT_MAX)) : CNT_W'(0)));

  // R6: an underflowing EOI rebuilds the count from the snapshot
  p_rebuild_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rebuild |=> pend_count == CNT_W'(sat_cnt($countones($past(cur_pending)), CNT_MAX)));

  // R8: one edge after reset is released the count is empty
  p_reset_r8: assert property (@(posedge clk)
    $rose(rst_sync_n) |-> pend_count == '0 && !coalesced);

endmodule

// File: tb/eoi_pend_tracker_tb.sv
module eoi_pend_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 8;
  localparam int VW = 8;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dlv_valid, dlv_ok, eoi_valid;
  logic [ND-1:0] dlv_mask, cur_pending;
  logic [VW-1:0] dlv_vector, eoi_vector, cur_vector;
  logic [2:0]    eoi_dest;
  logic          coalesced;
  logic [CW-1:0] pend_count;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state derived from the requirements
  logic          m_bit [ND];
  logic [VW-1:0] m_vec [ND];
  int            m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  eoi_pend_tracker #(.NUM_DEST(ND), .VEC_W(VW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_ok(dlv_ok),
    .dlv_mask(dlv_mask), .dlv_vector(dlv_vector), .eoi_valid(eoi_valid),
    .eoi_dest(eoi_dest), .eoi_vector(eoi_vector), .cur_pending(cur_pending),
    .cur_vector(cur_vector), .coalesced(coalesced), .pend_count(pend_count)
  );

  function automatic int pop8(input logic [ND-1:0] v);
    int c = 0;
    for (int i = 0; i < ND; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dlv_valid = 0; dlv_ok = 0; dlv_mask = '0; dlv_vector = '0;
    eoi_valid = 0; eoi_dest = '0; eoi_vector = '0;
    cur_pending = '0; cur_vector = '0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < ND; i++) begin m_bit[i] = 0; m_vec[i] = '0; end
    m_cnt = 0;
  endtask

  // One cycle of stimulus; called just after a falling edge.
  task automatic step(input string tag, input logic dv, input logic ok,
                      input logic [ND-1:0] mask, input logic [VW-1:0] vec,
                      input logic ev, input int ed, input logic [VW-1:0] evec,
                      input logic [ND-1:0] curp, input logic [VW-1:0] curv);
    logic hit;
    dlv_valid = dv; dlv_ok = ok; dlv_mask = mask; dlv_vector = vec;
    eoi_valid = ev; eoi_dest = ed[2:0]; eoi_vector = evec;
    cur_pending = curp; cur_vector = curv;
    if (dv && m_cnt == 0) begin
      for (int i = 0; i < ND; i++) if (mask[i]) begin m_bit[i] = 1; m_vec[i] = vec; end
      m_cnt = ok ? ((pop8(mask) > CMAX) ? CMAX : pop8(mask)) : 0;
    end
    if (ev) begin
      hit = m_bit[ed] && (m_vec[ed] == evec);
      if (hit) begin
        if (m_cnt == 0) begin
          for (int i = 0; i < ND; i++) begin
            m_bit[i] = curp[i];
            if (curp[i]) m_vec[i] = curv;
          end
          m_cnt = (pop8(curp) > CMAX) ? CMAX : pop8(curp);
        end else begin
          m_bit[ed] = 0;
          m_cnt--;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    chk(tag, int'(pend_count), m_cnt);
    chk("R1", int'(coalesced), int'(m_cnt != 0));
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R8", int'(pend_count), 0);
    chk("R8", int'(coalesced), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    @(negedge clk);
    do_reset();

    // R3 R4 R5 R2: every accept mask
    for (int m = 0; m < 256; m++) begin
      logic [VW-1:0] v, rv;
      v  = VW'(m) ^ 8'h5A;
      rv = v ^ 8'hC3;
      step("R3", 1, 1, ND'(m), v, 0, 0, '0, '0, '0);
      // refused delivery with complementary mask and a fresh vector
      step("R2", 1, 1, ~ND'(m), rv, 0, 0, '0, '0, '0);
      for (int d = 0; d < ND; d++)
        if (!m[d]) step("R2", 0, 0, '0, '0, 1, d, rv, 8'hFF, rv);
      for (int d = 0; d < ND; d++) begin
        step("R5", 0, 0, '0, '0, 1, d, v + 8'd1, 8'hFF, v);
        step("R4", 0, 0, '0, '0, 1, d, v, 8'hFF, v);
      end
    end

    // R6: failed delivery then underflowing EOI, every snapshot
    for (int p = 0; p < 256; p++) begin
      logic [VW-1:0] cv;
      cv = VW'(p) ^ 8'h96;
      if (cv == 8'h10) cv = 8'h11;
      step("R3", 1, 0, 8'h01, 8'h10, 0, 0, '0, '0, '0);
      step("R6", 0, 0, '0, '0, 1, 0, 8'h10, ND'(p), cv);
      for (int d = 0; d < ND; d++)
        if (p[d]) step("R6", 0, 0, '0, '0, 1, d, cv, '0, '0);
    end

    // R6 second snapshot and stale-bit behaviour
    step("R3", 1, 0, 8'h0F, 8'h33, 0, 0, '0, '0, '0);
    step("R6", 0, 0, '0, '0, 1, 1, 8'h33, 8'hA5, 8'h44);
    step("R6", 0, 0, '0, '0, 1, 0, 8'h44, '0, '0);
    step("R6", 0, 0, '0, '0, 1, 1, 8'h33, 8'hFF, 8'h44);
    step("R6", 0, 0, '0, '0, 1, 2, 8'h44, '0, '0);
    step("R6", 0, 0, '0, '0, 1, 5, 8'h44, '0, '0);
    step("R6", 0, 0, '0, '0, 1, 7, 8'h44, '0, '0);

    // R7: delivery and EOI in the same cycle
    step("R7", 1, 1, 8'h06, 8'h21, 1, 1, 8'h21, 8'hFF, 8'h21);
    step("R7", 0, 0, '0, '0, 1, 2, 8'h21, 8'hFF, 8'h21);
    step("R7", 1, 1, 8'h30, 8'h22, 1, 3, 8'h22, 8'hFF, 8'h22);
    step("R7", 0, 0, '0, '0, 1, 4, 8'h22, 8'hFF, 8'h22);
    step("R7", 0, 0, '0, '0, 1, 5, 8'h22, 8'hFF, 8'h22);

    // R8: reset while pending, then an EOI that would rebuild if bits survived
    step("R3", 1, 1, 8'hFF, 8'h77, 0, 0, '0, '0, '0);
    do_reset();
    step("R8", 0, 0, '0, '0, 1, 0, 8'h77, 8'hFF, 8'h77);
    step("R8", 0, 0, '0, '0, 1, 7, 8'h77, 8'hFF, 8'h77);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule